// File: doc/BRIEF.md
# Indirect Interrupt Routing Register Window

This block is the register front end of an I/O interrupt router. Software reaches it through only two bus locations. One location holds an 8-bit select value. The other is a 32-bit data window onto whichever internal register the select value names. Behind the window sit four things:

- a fixed version register;
- a 4-bit identifier that software can write;
- an arbitration register that mirrors the identifier and cannot be written;
- a table of 64-bit per-pin routing entries, each reached as two 32-bit halves.

The block holds the stored routing entries for the trigger and delivery logic next to it. It also samples the per-pin request lines into a pending register. Whenever software writes an entry, the block raises a one-cycle "table written" strobe for that pin. If the pin's request is pending at that moment, it also raises a "service again" strobe. The delivery logic sets an entry's in-service flag through a per-pin input. Software clears that flag by writing the lower half of the entry.

Each routing entry has a fixed field layout:

| Bits | Field |
|------|-------|
| 7:0 | vector |
| 10:8 | delivery mode |
| 11 | destination mode |
| 13 | polarity |
| 14 | in-service flag |
| 15 | trigger mode (1 = level) |
| 16 | mask |
| 63:56 | destination |

Top module: `irq_route_regs`

## Requirements
- R1: A bus write at low address byte 0x00 stores write-data bits 7:0 as the select value. A read there returns the select value zero-extended to 32 bits. Read data appears on `bus_rdata` the cycle after `bus_rd` and holds until the next read.
- R2: Only address bits 7:0 are decoded, so upper address bits have no effect. A read whose low byte is neither 0x00 nor 0x10 returns zero.
- R3: With select 0x01, a window read returns (NPINS−1) in bits 23:16 and VER_CODE in bits 7:0, with all other bits zero. Window writes at this select change nothing.
- R4: With select 0x00, a window write loads write-data bits 27:24 into the identifier. Window reads at select 0x00 and at select 0x02 both return the identifier in bits 27:24 and zero elsewhere. Window writes at select 0x02 change nothing.
- R5: A select value of 0x10 or above addresses entry (select − 0x10) >> 1. Select bit 0 set chooses entry bits 63:32, and bit 0 clear chooses bits 31:0. Selects 0x03 to 0x0F read as zero and ignore writes.
- R6: A write to one half of an entry leaves the other half of that entry, and every other entry, unchanged.
- R7: A window write whose entry index is NPINS or more changes no entry and raises no strobe. A window read at such an index returns zero.
- R8: Entry bit 14 (in-service) cannot be set from the bus. It is set the cycle after `rirr_set[n]` is high. A lower-half write clears it, and an upper-half write leaves it unchanged.
- R9: `tbl_wr[n]` pulses for exactly the cycle after a window write to entry n. `svc_req[n]` pulses in the same cycle when that pin's pending bit was set at the time of the write. The pending bit is `pin_req[n]` as sampled on the previous clock edge.
- R10: After reset, every entry reads as mask set (bit 16) and all other bits clear. The select value, the identifier and the pending bits are all zero.
- R11: `tbl_flat[64*n +: 64]` always presents the stored entry n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_addr | input | AW | Byte address; only bits 7:0 are decoded |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pin_req | input | NPINS | Per-pin request levels from the trigger logic |
| rirr_set | input | NPINS | Per-pin set of the in-service flag |
| tbl_flat | output | 64*NPINS | All stored routing entries, entry n at bits 64n+63:64n |
| tbl_wr | output | NPINS | One-cycle strobe: entry n was written |
| svc_req | output | NPINS | One-cycle strobe: entry n was written while its request was pending |

## Verification
Most internal errors in this block become visible at the ports within one or two cycles.

- A wrong select decode or entry-index computation puts a write into the wrong half or the wrong entry. This shows on `tbl_flat` and on the one-hot `tbl_wr` strobe in the very next cycle.
- A stale or misrouted read path shows in `bus_rdata` one cycle after the read strobe.
- A lost or spuriously set in-service flag shows in bit 14 of the affected entry on `tbl_flat` one cycle after the `rirr_set` pulse or the lower-half write.
- A pending register that lags or leads shows as a missing or extra `svc_req` pulse on the write that follows a request change.

// File: rtl/irr_pkg.sv
package irr_pkg;

    // Stored layout of one 64-bit routing entry
    typedef struct packed {
        logic [7:0]  dest;
        logic [38:0] rsvd_hi;
        logic        mask;
        logic        trig;
        logic        rirr;
        logic        pol;
        logic        rsvd12;
        logic        dmode;
        logic [2:0]  dlv;
        logic [7:0]  vec;
    } rte_t;

    // What the current select value addresses through the window
    typedef enum logic [2:0] {
        K_NONE,
        K_ID,
        K_VER,
        K_ARB,
        K_ENT
    } wkind_e;

    localparam int          SEL_W   = 8;
    localparam logic [7:0]  OFS_SEL = 8'h00;
    localparam logic [7:0]  OFS_WIN = 8'h10;
    localparam logic [7:0]  IX_ID   = 8'h00;
    localparam logic [7:0]  IX_VER  = 8'h01;
    localparam logic [7:0]  IX_ARB  = 8'h02;
    localparam logic [7:0]  IX_TBL  = 8'h10;
    localparam int          IDX_W   = 7;
    localparam rte_t        RTE_RST = rte_t'(64'h0000_0000_0001_0000);

endpackage

// File: rtl/irr_decode.sv
module irr_decode
    import irr_pkg::*;
#(
    parameter int NPINS = 24,
    parameter int AW    = 12
) (
    input  logic [AW-1:0]    bus_addr,
    input  logic [SEL_W-1:0] sel_q,
    output logic             is_sel,
    output logic             is_win,
    output wkind_e           kind,
    output logic [IDX_W-1:0] idx,
    output logic             hi,
    output logic             idx_ok
);
    logic [7:0] off;
    logic [7:0] rel;

    always_comb begin
        off    = bus_addr[7:0];
        is_sel = (off == OFS_SEL);
        is_win = (off == OFS_WIN);
        rel    = sel_q - IX_TBL;
        idx    = rel[7:1];
        hi     = sel_q[0];
        if (sel_q >= IX_TBL) begin
            kind = K_ENT;
        end else if (sel_q == IX_ID) begin
            kind = K_ID;
        end else if (sel_q == IX_VER) begin
            kind = K_VER;
        end else if (sel_q == IX_ARB) begin
            kind = K_ARB;
        end else begin
            kind = K_NONE;
        end
        idx_ok = (kind == K_ENT) && (int'(idx) < NPINS);
    end

endmodule

// File: rtl/irr_entry.sv
module irr_entry
    import irr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [31:0] wdata,
    input  logic        rirr_set,
    output logic [63:0] ent_o
);
    rte_t ent_d, ent_q;

    always_comb begin
        ent_d = ent_q;
        if (wr_hi) begin
            ent_d[63:32] = wdata;
        end
        if (wr_lo) begin
            ent_d[31:0] = wdata;
            ent_d.rirr  = 1'b0;
        end
        if (rirr_set) begin
            ent_d.rirr = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_q <= RTE_RST;
        end else begin
            ent_q <= ent_d;
        end
    end

    assign ent_o = ent_q;

endmodule

// File: rtl/irr_readmux.sv
module irr_readmux
    import irr_pkg::*;
#(
    parameter int         NPINS    = 24,
    parameter logic [7:0] VER_CODE = 8'h11
) (
    input  wkind_e             kind,
    input  logic [IDX_W-1:0]   idx,
    input  logic               hi,
    input  logic               idx_ok,
    input  logic [3:0]         id_q,
    input  logic [NPINS*64-1:0] tbl_flat,
    output logic [31:0]        win_val
);
    localparam logic [7:0] PIN_MAX = 8'(NPINS - 1);

    always_comb begin
        win_val = '0;
        unique case (kind)
            K_ID, K_ARB: win_val = {4'h0, id_q, 24'h0};
            K_VER:       win_val = {8'h00, PIN_MAX, 8'h00, VER_CODE};
            K_ENT: begin
                for (int p = 0; p < NPINS; p++) begin
                    if (idx_ok && (int'(idx) == p)) begin
                        win_val = hi ? tbl_flat[p*64+32 +: 32]
                                     : tbl_flat[p*64 +: 32];
                    end
                end
            end
            default:     win_val = '0;
        endcase
    end

endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
    import irr_pkg::*;
#(
    parameter int         NPINS    = 24,
    parameter int         AW       = 12,
    parameter logic [7:0] VER_CODE = 8'h11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [AW-1:0]       bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NPINS-1:0]    pin_req,
    input  logic [NPINS-1:0]    rirr_set,
    output logic [NPINS*64-1:0] tbl_flat,
    output logic [NPINS-1:0]    tbl_wr,
    output logic [NPINS-1:0]    svc_req
);
    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [3:0]       id;
        logic [NPINS-1:0] irr;
        logic [31:0]      rdata;
        logic [NPINS-1:0] wr;
        logic [NPINS-1:0] svc;
    } st_t;

    st_t st_d, st_q;

    logic             is_sel, is_win, hi, idx_ok;
    wkind_e           kind;
    logic [IDX_W-1:0] idx;
    logic [31:0]      win_val;
    logic [NPINS-1:0] wr_lo, wr_hi;

    irr_decode #(.NPINS(NPINS), .AW(AW)) u_dec (
        .bus_addr (bus_addr),
        .sel_q    (st_q.sel),
        .is_sel   (is_sel),
        .is_win   (is_win),
        .kind     (kind),
        .idx      (idx),
        .hi       (hi),
        .idx_ok   (idx_ok)
    );

    always_comb begin
        wr_lo = '0;
        wr_hi = '0;
        for (int p = 0; p < NPINS; p++) begin
            if (bus_wr && is_win && idx_ok && (int'(idx) == p)) begin
                wr_lo[p] = !hi;
                wr_hi[p] = hi;
            end
        end
    end

    for (genvar g = 0; g < NPINS; g++) begin : g_ent
        irr_entry u_ent (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_lo    (wr_lo[g]),
            .wr_hi    (wr_hi[g]),
            .wdata    (bus_wdata),
            .rirr_set (rirr_set[g]),
            .ent_o    (tbl_flat[g*64 +: 64])
        );
    end

    irr_readmux #(.NPINS(NPINS), .VER_CODE(VER_CODE)) u_rmux (
        .kind     (kind),
        .idx      (idx),
        .hi       (hi),
        .idx_ok   (idx_ok),
        .id_q     (st_q.id),
        .tbl_flat (tbl_flat),
        .win_val  (win_val)
    );

    always_comb begin
        st_d     = st_q;
        st_d.irr = pin_req;
        st_d.wr  = wr_lo | wr_hi;
        st_d.svc = (wr_lo | wr_hi) & st_q.irr;
        if (bus_wr && is_sel) begin
            st_d.sel = bus_wdata[SEL_W-1:0];
        end
        if (bus_wr && is_win && (kind == K_ID)) begin
            st_d.id = bus_wdata[27:24];
        end
        if (bus_rd) begin
            if (is_sel) begin
                st_d.rdata = {{(32-SEL_W){1'b0}}, st_q.sel};
            end else if (is_win) begin
                st_d.rdata = win_val;
            end else begin
                st_d.rdata = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;
    assign tbl_wr    = st_q.wr;
    assign svc_req   = st_q.svc;

endmodule

// File: rtl/irr_checker.sv
module irr_checker #(
    parameter int NPINS = 24,
    parameter int AW    = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_wr,
    input logic                bus_rd,
    input logic [AW-1:0]       bus_addr,
    input logic [31:0]         bus_rdata,
    input logic [NPINS-1:0]    rirr_set,
    input logic [NPINS*64-1:0] tbl_flat,
    input logic [NPINS-1:0]    tbl_wr,
    input logic [NPINS-1:0]    svc_req
);
    logic [NPINS-1:0]    rirr_v;
    logic [NPINS*64-1:0] keep_m;

    always_comb begin
        keep_m = '1;
        for (int p = 0; p < NPINS; p++) begin
            rirr_v[p]         = tbl_flat[p*64 + 14];
            keep_m[p*64 + 14] = 1'b0;
        end
    end

    p_other_ofs_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr[7:0] != 8'h00 && bus_addr[7:0] != 8'h10)
            |=> (bus_rdata == 32'h0));

    p_tbl_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(tbl_flat & keep_m));

    p_rirr_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((rirr_v & ~$past(rirr_v) & ~$past(rirr_set)) == '0));

    p_wr_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tbl_wr));

    p_svc_in_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_req & ~tbl_wr) == '0);

    p_no_wr_no_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> (tbl_wr == '0));

endmodule

bind irq_route_regs irr_checker #(.NPINS(NPINS), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .rirr_set  (rirr_set),
    .tbl_flat  (tbl_flat),
    .tbl_wr    (tbl_wr),
    .svc_req   (svc_req)
);

// File: tb/sim_irq_route_regs.sv
`timescale 1ns/1ps
module sim_irq_route_regs;
    localparam int         N   = 24;
    localparam int         AW  = 12;
    localparam logic [7:0] VER = 8'h11;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_wr = 1'b0, bus_rd = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [N-1:0]    pin_req = '0, rirr_set = '0;
    logic [N*64-1:0] tbl_flat;
    logic [N-1:0]    tbl_wr, svc_req;

    int n_cmp = 0;
    int n_bad = 0;

    logic [63:0] m_ent [N];
    logic [7:0]  m_sel;
    logic [3:0]  m_id;
    logic [N-1:0] m_req;

    always #4 clk = ~clk;

    irq_route_regs #(.NPINS(N), .AW(AW), .VER_CODE(VER)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_req(pin_req), .rirr_set(rirr_set), .tbl_flat(tbl_flat),
        .tbl_wr(tbl_wr), .svc_req(svc_req)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] win_exp();
        int ix;
        if (m_sel == 8'h00 || m_sel == 8'h02) return {4'h0, m_id, 24'h0};
        if (m_sel == 8'h01) return {8'h00, 8'(N - 1), 8'h00, VER};
        if (m_sel < 8'h10) return 32'h0;
        ix = int'((m_sel - 8'h10) >> 1);
        if (ix >= N) return 32'h0;
        return m_sel[0] ? m_ent[ix][63:32] : m_ent[ix][31:0];
    endfunction

    function automatic logic [31:0] rd_exp(input logic [AW-1:0] a);
        if (a[7:0] == 8'h00) return {24'h0, m_sel};
        if (a[7:0] == 8'h10) return win_exp();
        return 32'h0;
    endfunction

    task automatic check_table(input string tag);
        for (int p = 0; p < N; p++) chk(tag, tbl_flat[p*64 +: 64], m_ent[p]);
    endtask

    task automatic do_read(input logic [AW-1:0] a, input string tag);
        logic [31:0] e;
        e = rd_exp(a);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        chk(tag, {32'h0, bus_rdata}, {32'h0, e});
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [31:0] d, input string tag);
        logic [N-1:0] ew, es;
        int ix;
        ew = '0;
        es = '0;
        if (a[7:0] == 8'h10) begin
            if (m_sel == 8'h00) m_id = d[27:24];
            else if (m_sel >= 8'h10) begin
                ix = int'((m_sel - 8'h10) >> 1);
                if (ix < N) begin
                    if (m_sel[0]) m_ent[ix][63:32] = d;
                    else begin
                        m_ent[ix][31:0] = d;
                        m_ent[ix][14]   = 1'b0;
                    end
                    ew[ix] = 1'b1;
                    es[ix] = m_req[ix];
                end
            end
        end
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a[7:0] == 8'h00) m_sel = d[7:0];
        chk({tag, " strobe R9"}, {40'h0, tbl_wr}, {40'h0, ew});
        chk({tag, " service R9"}, {40'h0, svc_req}, {40'h0, es});
        check_table({tag, " table R11"});
    endtask

    task automatic set_req(input logic [N-1:0] v);
        @(negedge clk);
        pin_req = v;
        m_req = v;
        @(negedge clk);
    endtask

    task automatic pulse_rirr(input int p);
        @(negedge clk);
        rirr_set = '0;
        rirr_set[p] = 1'b1;
        @(negedge clk);
        rirr_set = '0;
        m_ent[p][14] = 1'b1;
        chk("R8 in-service set", tbl_flat[p*64 +: 64], m_ent[p]);
    endtask

    initial begin
        #(8ns * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd7));
        for (int p = 0; p < N; p++) m_ent[p] = 64'h0000_0000_0001_0000;
        m_sel = 8'h00;
        m_id = 4'h0;
        m_req = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check_table("R10 reset entries");
        chk("R10 strobes", {40'h0, tbl_wr | svc_req}, 64'h0);
        do_read(12'h000, "R10 R1 select after reset");
        do_read(12'h010, "R10 R4 id after reset");
        // R3 version
        do_write(12'h000, 32'h0000_0001, "R1 select ver");
        do_read(12'h000, "R1 select readback");
        do_read(12'h010, "R3 version");
        do_write(12'h010, 32'hFFFF_FFFF, "R3 ver write");
        do_read(12'h010, "R3 version after write");
        // R4 identifier
        do_write(12'h000, 32'h0000_0000, "R4 sel id");
        do_write(12'h010, 32'hA5FF_FFFF, "R4 id write");
        do_read(12'h010, "R4 id read");
        do_write(12'h000, 32'h0000_0002, "R4 sel arb");
        do_read(12'h010, "R4 arb mirrors id");
        do_write(12'h010, 32'h0300_0000, "R4 arb write");
        do_read(12'h010, "R4 arb unchanged");
        // R5 unused selects
        do_write(12'h000, 32'h0000_0007, "R5 sel 07");
        do_write(12'h010, 32'h1234_5678, "R5 unused write");
        do_read(12'h010, "R5 unused read zero");
        // R2 other offsets and upper address bits
        do_read(12'h020, "R2 other offset");
        do_read(12'h004, "R2 offset 04");
        do_read(12'hF00, "R2 upper bits select");
        // R5 R6 last entry halves
        do_write(12'h000, 32'h0000_003F, "R5 sel last hi");
        do_write(12'hA10, 32'hDEAD_BEEF, "R5 R2 last hi");
        do_read(12'h010, "R5 last hi read");
        do_write(12'h000, 32'h0000_003E, "R5 sel last lo");
        do_write(12'h010, 32'h0001_C0A5, "R6 last lo");
        do_read(12'h010, "R5 R8 last lo read");
        // R7 out of range
        do_write(12'h000, 32'h0000_0040, "R7 sel idx24");
        do_write(12'h010, 32'hFFFF_FFFF, "R7 idx24 write");
        do_read(12'h010, "R7 idx24 read");
        do_write(12'h000, 32'h0000_00FF, "R7 sel top");
        do_write(12'h010, 32'h5555_5555, "R7 top write");
        // R8 in-service flag
        pulse_rirr(3);
        do_write(12'h000, 32'h0000_0017, "R8 sel e3 hi");
        do_write(12'h010, 32'h0F00_0000, "R8 hi keeps flag");
        do_write(12'h000, 32'h0000_0016, "R8 sel e3 lo");
        do_write(12'h010, 32'h0000_4031, "R8 lo clears flag");
        // R9 service request
        set_req(24'h000008);
        do_write(12'h010, 32'h0000_8031, "R9 pending write");
        set_req('0);
        do_write(12'h010, 32'h0000_8032, "R9 idle write");
        // random mix
        for (int it = 0; it < 600; it++) begin
            int op;
            logic [AW-1:0] ra;
            op = int'($urandom_range(0, 9));
            ra = AW'($urandom);
            if (op < 3) begin
                do_write(12'h000, {24'h0, 8'($urandom_range(0, 8'h45))}, "R1 R5 rnd sel");
            end else if (op < 6) begin
                do_write({ra[AW-1:8], 8'h10}, $urandom, "R6 rnd window write");
            end else if (op < 8) begin
                ra[7:0] = ($urandom_range(0, 3) == 0) ? ra[7:0] :
                          ($urandom_range(0, 1) == 0 ? 8'h00 : 8'h10);
                do_read(ra, "R2 R5 rnd read");
            end else if (op == 8) begin
                pulse_rirr(int'($urandom_range(0, N - 1)));
            end else begin
                set_req(N'($urandom));
            end
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule